// File: doc/BRIEF.md
# Processor Status Flag Register with Branch Condition Select

This block holds the eight status bits of a small microcoded processor. Each bit has its own active-low load enable from the microcode. A clocked load happens only on the cycle in which the main clock phase input falls. Every bit can also be forced to one or to zero directly, on any clock edge, for instructions that set or clear a single flag. The carry, zero, overflow and negative bits take their load value either from the data bus or from the ALU flag outputs, under one source select. The interrupt-disable, decimal, break and mode bits always load from the data bus. Bit 5 is a real storage bit that records an 8/16-bit operating mode.

The microcode uses two further paths. The first is a readback that places the whole register on the data-out lines, for push-status style operations. The restore-status path is an ordinary load of all bits from the data bus. The second is a 3-bit selector that routes any one stored bit to a branch-condition output, which the decoder uses to decide whether a branch is taken.

Bit layout (position = index): 0 carry, 1 zero, 2 interrupt disable, 3 decimal, 4 break, 5 mode, 6 overflow, 7 negative.

Top module: `sfr_status_reg`

## Requirements
- R1: After reset the register holds 8'h04, meaning only the interrupt-disable bit (bit 2) is set.
- R2: A clocked load happens only at a clock edge where `phase` is 0 and was 1 at the previous edge. With `phase` held at 0 or held at 1, no bit changes, even when every `load_n` bit is 0.
- R3: `load_n[i]` is active low. At a qualifying load edge, bit i takes its source value when `load_n[i]` is 0 and keeps its value when `load_n[i]` is 1.
- R4: When `alu_sel` is 1, bits 0, 1, 6 and 7 load from `alu_carry`, `alu_zero`, `alu_ovf` and `alu_neg` respectively. When `alu_sel` is 0, they load from `data_in` bits 0, 1, 6 and 7.
- R5: Bits 2, 3, 4 and 5 load from `data_in` bits 2, 3, 4 and 5 whatever the value of `alu_sel`.
- R6: `set_bits[i]` high forces bit i to 1 at the next clock edge, whatever `phase` is doing.
- R7: `clr_bits[i]` high forces bit i to 0 at the next clock edge. When set and clear are both high for a bit, clear wins.
- R8: When a set or a clear coincides with a qualifying load of the same bit, the set or clear decides that bit.
- R9: `branch_cond` equals the stored bit whose index is `br_sel`, where `br_sel` values 0 to 7 select bits 0 to 7. The output follows `br_sel` and the register without any added clock delay.
- R10: When `rd_oe` is 1, `data_out` carries the whole register in the same cycle. When `rd_oe` is 0, `data_out` is 8'h00.
- R11: The mode bit (bit 5) stores a value loaded from `data_in[5]`, and it appears on `branch_cond` when `br_sel` is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 1 | Main clock phase; a 1-to-0 step qualifies a load |
| load_n | input | 8 | Per-bit active-low load enables |
| set_bits | input | 8 | Per-bit force-to-one |
| clr_bits | input | 8 | Per-bit force-to-zero |
| alu_sel | input | 1 | 1 selects ALU flags for bits 0, 1, 6, 7 |
| alu_carry | input | 1 | ALU carry result |
| alu_zero | input | 1 | ALU zero result |
| alu_ovf | input | 1 | ALU overflow result |
| alu_neg | input | 1 | ALU negative result |
| data_in | input | 8 | Data bus into the register |
| rd_oe | input | 1 | Readback enable |
| data_out | output | 8 | Register readback, zero when not enabled |
| br_sel | input | 3 | Branch condition bit select |
| branch_cond | output | 1 | Selected flag bit |

## Verification
A load takes two clock edges. The edge with `phase` at 1 records the phase, and the following edge with `phase` at 0 writes the bits. The bench therefore drives `phase` high for one cycle and low for the next, and reads the register back after the second edge. Set and clear take effect at the first edge after they are applied, so the bench samples at the falling clock edge that follows. Readback and branch select add no register, so they are checked a short delay after their select inputs change, away from any edge. The bench computes every expected register value from the previous expected value, the enable mask and the source rule.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int FLAG_W   = 8;
  localparam int POS_C    = 0;
  localparam int POS_Z    = 1;
  localparam int POS_I    = 2;
  localparam int POS_D    = 3;
  localparam int POS_B    = 4;
  localparam int POS_MODE = 5;
  localparam int POS_V    = 6;
  localparam int POS_N    = 7;

  // Priority: clear, then set, then clocked load, else hold.
  function automatic logic next_flag(input logic cur, input logic set_i,
                                     input logic clr_i, input logic ld_i,
                                     input logic d_i);
    logic r;
    if (clr_i)      r = 1'b0;
    else if (set_i) r = 1'b1;
    else if (ld_i)  r = d_i;
    else            r = cur;
    return r;
  endfunction
endpackage

// File: rtl/sfr_phase_edge.sv
module sfr_phase_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  output logic fall
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase;
  end

  assign fall = phase_q & ~phase;
endmodule

// File: rtl/sfr_src_mux.sv
module sfr_src_mux #(
  parameter int W = sfr_pkg::FLAG_W
) (
  input  logic         alu_sel,
  input  logic [3:0]   alu_flags,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] d_out
);
  import sfr_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_lane
    if (i == POS_C) begin : g_c
      assign d_out[i] = alu_sel ? alu_flags[0] : data_in[i];
    end else if (i == POS_Z) begin : g_z
      assign d_out[i] = alu_sel ? alu_flags[1] : data_in[i];
    end else if (i == POS_V) begin : g_v
      assign d_out[i] = alu_sel ? alu_flags[2] : data_in[i];
    end else if (i == POS_N) begin : g_n
      assign d_out[i] = alu_sel ? alu_flags[3] : data_in[i];
    end else begin : g_data
      assign d_out[i] = data_in[i];
    end
  end
endmodule

// File: rtl/sfr_bit_cell.sv
module sfr_bit_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_fire,
  input  logic load_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q
);
  import sfr_pkg::*;

  logic ld_now;
  assign ld_now = ld_fire & ~load_n;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= next_flag(q, set_i, clr_i, ld_now, d_i);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_fire && !set_i && !clr_i) |=> $stable(q));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !set_i && !clr_i) |=> $stable(q));

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q);

  assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q);

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !load_n && !set_i && !clr_i) |=> (q == $past(d_i)));
endmodule

// File: rtl/sfr_branch_sel.sv
module sfr_branch_sel #(
  parameter int W = sfr_pkg::FLAG_W,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  flags,
  input  logic [SW-1:0] sel,
  output logic          cond
);
  always_comb begin
    cond = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (sel == k[SW-1:0]) cond = flags[k];
    end
  end
endmodule

// File: rtl/sfr_status_reg.sv
module sfr_status_reg #(
  parameter int         W       = sfr_pkg::FLAG_W,
  parameter logic [7:0] RST_VAL = 8'h04,
  localparam int        SW      = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase,
  input  logic [W-1:0]  load_n,
  input  logic [W-1:0]  set_bits,
  input  logic [W-1:0]  clr_bits,
  input  logic          alu_sel,
  input  logic          alu_carry,
  input  logic          alu_zero,
  input  logic          alu_ovf,
  input  logic          alu_neg,
  input  logic [W-1:0]  data_in,
  input  logic          rd_oe,
  output logic [W-1:0]  data_out,
  input  logic [SW-1:0] br_sel,
  output logic          branch_cond
);
  logic         ld_fire;
  logic [W-1:0] src_d;
  logic [W-1:0] flags;

  sfr_phase_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .fall  (ld_fire)
  );

  sfr_src_mux #(.W(W)) u_src (
    .alu_sel   (alu_sel),
    .alu_flags ({alu_neg, alu_ovf, alu_zero, alu_carry}),
    .data_in   (data_in),
    .d_out     (src_d)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    sfr_bit_cell #(.RST_VAL(RST_VAL[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_fire (ld_fire),
      .load_n  (load_n[i]),
      .set_i   (set_bits[i]),
      .clr_i   (clr_bits[i]),
      .d_i     (src_d[i]),
      .q       (flags[i])
    );
  end

  sfr_branch_sel #(.W(W)) u_br (
    .flags (flags),
    .sel   (br_sel),
    .cond  (branch_cond)
  );

  assign data_out = rd_oe ? flags : '0;

  assert_fire_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |-> ($past(phase) && !phase));

  assert_alu_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && alu_sel && !load_n[0] && !set_bits[0] && !clr_bits[0])
      |=> (flags[0] == $past(alu_carry)));

  assert_data_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && alu_sel && !load_n[3] && !set_bits[3] && !clr_bits[3])
      |=> (flags[3] == $past(data_in[3])));

  assert_mode_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (br_sel == 3'd5) |-> (branch_cond == flags[5]));
endmodule

// File: tb/sfr_status_reg_tb_top.sv
`timescale 1ns/1ps
module sfr_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase = 1'b0;
  logic [7:0] load_n = 8'hFF;
  logic [7:0] set_bits = 8'h00;
  logic [7:0] clr_bits = 8'h00;
  logic       alu_sel = 1'b0;
  logic       alu_carry = 1'b0, alu_zero = 1'b0, alu_ovf = 1'b0, alu_neg = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       rd_oe = 1'b0;
  logic [7:0] data_out;
  logic [2:0] br_sel = 3'd0;
  logic       branch_cond;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  sfr_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .load_n(load_n),
    .set_bits(set_bits), .clr_bits(clr_bits), .alu_sel(alu_sel),
    .alu_carry(alu_carry), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
    .alu_neg(alu_neg), .data_in(data_in), .rd_oe(rd_oe),
    .data_out(data_out), .br_sel(br_sel), .branch_cond(branch_cond)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(output logic [7:0] v);
    rd_oe = 1'b1;
    #1;
    v = data_out;
    rd_oe = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    read_reg(v);
    chk(tag, v, exp);
  endtask

  // Drive a full phase high/low sequence with the given enables.
  task automatic do_load(input logic [7:0] en_n, input logic [7:0] d,
                         input logic asel, input logic [3:0] nvzc);
    @(negedge clk);
    phase = 1'b1;
    load_n = en_n; data_in = d; alu_sel = asel;
    {alu_neg, alu_ovf, alu_zero, alu_carry} = nvzc;
    @(negedge clk);
    phase = 1'b0;
    @(negedge clk);
    load_n = 8'hFF;
  endtask

  function automatic logic [7:0] src_of(input logic [7:0] d, input logic asel,
                                        input logic [3:0] nvzc);
    logic [7:0] s;
    s = d;
    if (asel) begin
      s[0] = nvzc[0]; s[1] = nvzc[1]; s[6] = nvzc[2]; s[7] = nvzc[3];
    end
    return s;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value
    chk_reg("R1 reset", 8'h04);
    model = 8'h04;
    rd_oe = 1'b0; #1;
    chk("R10 readback disabled", data_out, 8'h00);

    // R4/R5: ALU source, all 16 ALU flag combinations, two data patterns
    for (int p = 0; p < 2; p++) begin
      for (int f = 0; f < 16; f++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'h3C : 8'hC3;
        do_load(8'h00, d, 1'b1, f[3:0]);
        model = src_of(d, 1'b1, f[3:0]);
        chk_reg("R4 R5 alu source load", model);
      end
    end
    // R4 data source for ALU lanes, R5 restore from bus
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'h01 << k;
      do_load(8'h00, d, 1'b0, 4'hF);
      model = d;
      chk_reg("R4 data source load", model);
    end

    // R3: enable masks, high enables ignored
    for (int m = 0; m < 8; m++) begin
      logic [7:0] en;
      logic [7:0] d;
      en = (8'h01 << m) | (8'h80 >> m);
      d = ~model ^ 8'h5A;
      do_load(~en, d, 1'b0, 4'h0);
      model = (model & ~en) | (d & en);
      chk_reg("R3 masked load", model);
    end
    do_load(8'hFF, ~model, 1'b0, 4'h0);
    chk_reg("R3 all enables high", model);

    // R2: no phase fall -> no change
    @(negedge clk);
    phase = 1'b0; load_n = 8'h00; data_in = ~model;
    repeat (3) @(negedge clk);
    chk_reg("R2 phase held low", model);
    phase = 1'b1;
    repeat (3) @(negedge clk);
    chk_reg("R2 phase held high", model);
    load_n = 8'hFF; phase = 1'b0;
    @(negedge clk);
    chk_reg("R2 fall with enables high", model);

    // R6/R7: direct set and clear on each bit
    for (int k = 0; k < 8; k++) begin
      set_bits = 8'h01 << k;
      @(negedge clk);
      set_bits = 8'h00;
      model[k] = 1'b1;
      chk_reg("R6 direct set", model);
      clr_bits = 8'h01 << k;
      @(negedge clk);
      clr_bits = 8'h00;
      model[k] = 1'b0;
      chk_reg("R7 direct clear", model);
    end
    set_bits = 8'hFF; clr_bits = 8'h0F;
    @(negedge clk);
    set_bits = 8'h00; clr_bits = 8'h00;
    model = 8'hF0;
    chk_reg("R7 clear beats set", model);

    // R8: set/clear vs load on the same edge
    @(negedge clk);
    phase = 1'b1; load_n = 8'h00; data_in = 8'h0F; alu_sel = 1'b0;
    @(negedge clk);
    phase = 1'b0; set_bits = 8'h30; clr_bits = 8'h03;
    @(negedge clk);
    load_n = 8'hFF; set_bits = 8'h00; clr_bits = 8'h00;
    model = (8'h0F | 8'h30) & ~8'h03;
    chk_reg("R8 set clear over load", model);

    // R9/R11: every branch select over two patterns
    for (int p = 0; p < 2; p++) begin
      logic [7:0] pat;
      pat = (p == 0) ? 8'hA5 : 8'h5A;
      do_load(8'h00, pat, 1'b0, 4'h0);
      model = pat;
      for (int s = 0; s < 8; s++) begin
        br_sel = s[2:0];
        #1;
        chk((s == 5) ? "R11 mode bit branch" : "R9 branch select",
            {7'd0, branch_cond}, {7'd0, pat[s]});
      end
    end
    // R11: mode bit toggled alone, R10 readback
    do_load(8'hDF, 8'h20, 1'b1, 4'h0);
    model[5] = 1'b0 | 1'b1;
    br_sel = 3'd5; #1;
    chk("R11 mode bit set", {7'd0, branch_cond}, 8'h01);
    chk_reg("R10 readback full", model);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule